// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits beside the instruction pipeline of a 32-bit core. Each cycle it looks at the pending exception requests, ignores the ones the current status register masks, and picks one under a fixed priority. On the next clock edge it presents the complete entry update as one registered bundle with a one-cycle strobe. The bundle holds the new current status (mode field, mask bits, endianness, cleared T and J bits), the value to save into the target mode's saved status register, the return link value and the vector fetch address.

A secure monitor call is split two ways. From user mode it becomes an undefined-instruction entry through the secure vector base. From a privileged mode it enters monitor mode through the monitor base. A precise abort on an external access is also sent to monitor mode when the external-abort routing bit is set.

In the cycle after any entry, the block works from the status and vector it has just produced, not from its inputs. In that cycle only a fast interrupt, or the reset request, can be taken. This lets a fast interrupt that arrived together with a precise data abort be entered right behind it, with its link pointing into the abort handler.

The entry bundle is a control strobe with no back-pressure. The core must accept it in the cycle it is shown.

Top module: `exc_entry_seq`

## Requirements
- R1: Priority from highest to lowest is reset, precise data abort, fast interrupt, normal interrupt, prefetch abort, imprecise data abort, then breakpoint, undefined, supervisor call and monitor call. The winner is reported on `ent_cause` with this encoding: 0 none, 1 reset, 2 data abort, 3 data abort routed to monitor, 4 fast interrupt, 5 interrupt, 6 prefetch abort, 7 imprecise abort, 8 breakpoint, 9 undefined, 10 supervisor call, 11 monitor call taken as undefined, 12 monitor call.
- R2: A masked request does not compete, and a lower request wins in its place. Status bit 6 masks the fast interrupt, bit 7 masks the normal interrupt and bit 8 masks the imprecise abort. Reset is never masked.
- R3: The new status keeps every bit of the old status except these: bits [4:0] take the target mode, bits 5 (T) and 24 (J) are cleared, and bit 9 takes `sec_ee`. Bits 6/7/8 are set as follows: fast interrupt sets 6 and 7; normal interrupt, aborts and breakpoint set 7 and 8; undefined and supervisor call set 7; the monitor paths and reset set 6, 7 and 8. The target modes are abort 10111, fast interrupt 10001, interrupt 10010, supervisor 10011, undefined 11011 and monitor 10110.
- R4: `ent_spsr` equals the status the entry was taken from. `ent_link` is the instruction address plus 8 for the three data-abort causes, plus 4 for every other cause, and 0 for reset.
- R5: The vector is a base plus an offset. The offsets are 0x00 for reset, 0x04 for undefined, 0x08 for supervisor call, 0x0C for prefetch abort and breakpoint, 0x10 for data aborts, 0x18 for interrupt and 0x1C for fast interrupt. The base is 0xFFFF0000 when `hi_vectors` is set. Otherwise it is `ns_base`, or zero for reset.
- R6: A monitor call with `in_user` set enters undefined mode. Its vector is 0xFFFF0004 when `hi_vectors` is set, else `sec_base` + 0x04.
- R7: A monitor call with `in_user` clear enters monitor mode. Its vector is `mon_base` + 0x08 whatever `hi_vectors` is.
- R8: A precise data abort with both `dabt_external` and `ea_route` set enters monitor mode with bits 6, 7 and 8 set, at `mon_base` + 0x10. A fast interrupt still held in the next cycle is therefore not entered.
- R9: In the cycle after an entry, the status and instruction address used are the ones just produced (`ent_cpsr`, `ent_vector`). Only the reset request and an unmasked fast interrupt are considered; every other request is ignored for that cycle.
- R10: The entry appears on the clock edge after the requests are sampled. `ent_valid` is high for one cycle per entry. When no entry is taken, `ent_valid` is 0 and `ent_cause` is 0. After reset, all outputs are zero.
- R11: Reset entry selects supervisor mode at vector 0x00000000, or at 0xFFFF0000 with high vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_reset | input | 1 | Reset exception request |
| req_dabt | input | 1 | Precise data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt_imp | input | 1 | Imprecise data abort request |
| req_bkpt | input | 1 | Breakpoint instruction |
| req_undef | input | 1 | Undefined instruction |
| req_svc | input | 1 | Supervisor call instruction |
| req_smc | input | 1 | Secure monitor call instruction |
| dabt_external | input | 1 | Precise abort came from an external access |
| ea_route | input | 1 | External-abort routing to monitor enabled |
| cur_psr | input | 32 | Current status register |
| cur_pc | input | 32 | Address of the current instruction |
| in_user | input | 1 | Core is in user mode |
| hi_vectors | input | 1 | High vector table selected |
| sec_base | input | 32 | Secure vector base |
| ns_base | input | 32 | Non-secure vector base |
| mon_base | input | 32 | Monitor vector base |
| sec_ee | input | 1 | Secure exception endianness bit |
| ent_valid | output | 1 | One-cycle entry strobe |
| ent_cause | output | 4 | Cause taken (R1 encoding) |
| ent_cpsr | output | 32 | New current status |
| ent_spsr | output | 32 | Value for the target saved status register |
| ent_link | output | 32 | Return link value |
| ent_vector | output | 32 | Vector fetch address |

## Verification
The checks assume that at most one of the four instruction-borne requests (breakpoint, undefined, supervisor call, monitor call) is high in any cycle. An input property flags any breach of this. Every stimulus row and directed case raises at most one of them, even when it stacks all the higher-priority requests. The properties also assume the core drops an instruction-borne request once the entry has been taken. The bench clears every request line after each entry, and holds only a fast interrupt or interrupt into the follow-on cycle, to test chaining and the rule that other requests are ignored in that cycle.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int PSR_W = 32;
  localparam int MODE_W = 5;
  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;
  localparam int BIT_A = 8;
  localparam int BIT_E = 9;
  localparam int BIT_J = 24;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_MON = 5'b10110;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

  typedef enum logic [3:0] {
    CAUSE_NONE     = 4'd0,
    CAUSE_RESET    = 4'd1,
    CAUSE_DABT     = 4'd2,
    CAUSE_DABT_MON = 4'd3,
    CAUSE_FIQ      = 4'd4,
    CAUSE_IRQ      = 4'd5,
    CAUSE_PABT     = 4'd6,
    CAUSE_DABT_IMP = 4'd7,
    CAUSE_BKPT     = 4'd8,
    CAUSE_UND      = 4'd9,
    CAUSE_SVC      = 4'd10,
    CAUSE_SMC_UND  = 4'd11,
    CAUSE_SMC_MON  = 4'd12
  } exc_cause_e;

  typedef enum logic [1:0] {
    BASE_ZERO = 2'd0,
    BASE_NS   = 2'd1,
    BASE_SEC  = 2'd2,
    BASE_MON  = 2'd3
  } base_sel_e;

  typedef struct packed {
    logic rst;
    logic dabt;
    logic fiq;
    logic irq;
    logic pabt;
    logic dabt_imp;
    logic bkpt;
    logic undef;
    logic svc;
    logic smc;
  } exc_req_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
(
  input  exc_req_t   req,
  input  logic [2:0] masks,      // {A, I, F} from the working status
  input  logic       follow_on,
  input  logic       user,
  input  logic       ext_abort,
  input  logic       route_ea,
  output exc_cause_e cause
);
  logic fiq_ok, irq_ok, imp_ok;

  assign fiq_ok = req.fiq && !masks[0];
  assign irq_ok = req.irq && !masks[1];
  assign imp_ok = req.dabt_imp && !masks[2];

  always_comb begin
    cause = CAUSE_NONE;
    if (req.rst) begin
      cause = CAUSE_RESET;
    end else if (follow_on) begin
      if (fiq_ok) cause = CAUSE_FIQ;
    end else if (req.dabt) begin
      cause = (ext_abort && route_ea) ? CAUSE_DABT_MON : CAUSE_DABT;
    end else if (fiq_ok) begin
      cause = CAUSE_FIQ;
    end else if (irq_ok) begin
      cause = CAUSE_IRQ;
    end else if (req.pabt) begin
      cause = CAUSE_PABT;
    end else if (imp_ok) begin
      cause = CAUSE_DABT_IMP;
    end else if (req.bkpt) begin
      cause = CAUSE_BKPT;
    end else if (req.undef) begin
      cause = CAUSE_UND;
    end else if (req.svc) begin
      cause = CAUSE_SVC;
    end else if (req.smc) begin
      cause = user ? CAUSE_SMC_UND : CAUSE_SMC_MON;
    end
  end
endmodule

// File: rtl/exc_state_gen.sv
module exc_state_gen
  import exc_seq_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  exc_cause_e        cause,
  input  logic [PSR_W-1:0]  old_psr,
  input  logic [ADDR_W-1:0] pc,
  input  logic              hi_vec,
  input  logic [ADDR_W-1:0] base_sec,
  input  logic [ADDR_W-1:0] base_ns,
  input  logic [ADDR_W-1:0] base_mon,
  input  logic              ee,
  output logic [PSR_W-1:0]  new_psr,
  output logic [ADDR_W-1:0] link,
  output logic [ADDR_W-1:0] vector
);
  localparam int OFF_W = 8;

  logic [MODE_W-1:0] mode;
  logic              set_f, set_i, set_a;
  logic [OFF_W-1:0]  offset;
  logic [3:0]        link_add;
  logic              link_zero;
  base_sel_e         bsel;
  logic [ADDR_W-1:0] base;

  always_comb begin
    mode      = MODE_SVC;
    set_f     = 1'b0;
    set_i     = 1'b1;
    set_a     = 1'b1;
    offset    = 8'h00;
    link_add  = 4'd4;
    link_zero = 1'b0;
    bsel      = BASE_NS;
    unique case (cause)
      CAUSE_RESET:    begin set_f = 1'b1; bsel = BASE_ZERO; link_zero = 1'b1; end
      CAUSE_DABT:     begin mode = MODE_ABT; offset = 8'h10; link_add = 4'd8; end
      CAUSE_DABT_MON: begin mode = MODE_MON; set_f = 1'b1; offset = 8'h10;
                            link_add = 4'd8; bsel = BASE_MON; end
      CAUSE_FIQ:      begin mode = MODE_FIQ; set_f = 1'b1; set_a = 1'b0; offset = 8'h1C; end
      CAUSE_IRQ:      begin mode = MODE_IRQ; offset = 8'h18; end
      CAUSE_PABT:     begin mode = MODE_ABT; offset = 8'h0C; end
      CAUSE_DABT_IMP: begin mode = MODE_ABT; offset = 8'h10; link_add = 4'd8; end
      CAUSE_BKPT:     begin mode = MODE_ABT; offset = 8'h0C; end
      CAUSE_UND:      begin mode = MODE_UND; set_a = 1'b0; offset = 8'h04; end
      CAUSE_SVC:      begin set_a = 1'b0; offset = 8'h08; end
      CAUSE_SMC_UND:  begin mode = MODE_UND; set_a = 1'b0; offset = 8'h04; bsel = BASE_SEC; end
      CAUSE_SMC_MON:  begin mode = MODE_MON; set_f = 1'b1; offset = 8'h08; bsel = BASE_MON; end
      default:        begin set_i = 1'b0; set_a = 1'b0; link_zero = 1'b1; bsel = BASE_ZERO; end
    endcase
  end

  always_comb begin
    unique case (bsel)
      BASE_NS:  base = base_ns;
      BASE_SEC: base = base_sec;
      BASE_MON: base = base_mon;
      default:  base = '0;
    endcase
    if (hi_vec && bsel != BASE_MON) base = HI_BASE[ADDR_W-1:0];
  end

  assign vector = base + ADDR_W'(offset);
  assign link   = link_zero ? '0 : pc + ADDR_W'(link_add);

  always_comb begin
    new_psr = old_psr;
    new_psr[MODE_W-1:0] = mode;
    new_psr[BIT_T] = 1'b0;
    new_psr[BIT_J] = 1'b0;
    new_psr[BIT_E] = ee;
    if (set_f) new_psr[BIT_F] = 1'b1;
    if (set_i) new_psr[BIT_I] = 1'b1;
    if (set_a) new_psr[BIT_A] = 1'b1;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset,
  input  logic              req_dabt,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic              req_pabt,
  input  logic              req_dabt_imp,
  input  logic              req_bkpt,
  input  logic              req_undef,
  input  logic              req_svc,
  input  logic              req_smc,
  input  logic              dabt_external,
  input  logic              ea_route,
  input  logic [31:0]       cur_psr,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              in_user,
  input  logic              hi_vectors,
  input  logic [ADDR_W-1:0] sec_base,
  input  logic [ADDR_W-1:0] ns_base,
  input  logic [ADDR_W-1:0] mon_base,
  input  logic              sec_ee,
  output logic              ent_valid,
  output logic [3:0]        ent_cause,
  output logic [31:0]       ent_cpsr,
  output logic [31:0]       ent_spsr,
  output logic [ADDR_W-1:0] ent_link,
  output logic [ADDR_W-1:0] ent_vector
);
  exc_req_t          req;
  exc_cause_e        cause;
  logic [PSR_W-1:0]  work_psr;
  logic [ADDR_W-1:0] work_pc;
  logic [PSR_W-1:0]  nxt_psr;
  logic [ADDR_W-1:0] nxt_link, nxt_vec;

  assign req = '{rst: req_reset, dabt: req_dabt, fiq: req_fiq, irq: req_irq,
                 pabt: req_pabt, dabt_imp: req_dabt_imp, bkpt: req_bkpt,
                 undef: req_undef, svc: req_svc, smc: req_smc};

  // Follow-on cycle: work from the bundle just produced.
  assign work_psr = ent_valid ? ent_cpsr   : cur_psr;
  assign work_pc  = ent_valid ? ent_vector : cur_pc;

  exc_arbiter u_arb (
    .req       (req),
    .masks     (work_psr[BIT_A:BIT_F]),
    .follow_on (ent_valid),
    .user      (in_user),
    .ext_abort (dabt_external),
    .route_ea  (ea_route),
    .cause     (cause)
  );

  exc_state_gen #(.ADDR_W(ADDR_W), .HI_BASE(HI_BASE)) u_gen (
    .cause    (cause),
    .old_psr  (work_psr),
    .pc       (work_pc),
    .hi_vec   (hi_vectors),
    .base_sec (sec_base),
    .base_ns  (ns_base),
    .base_mon (mon_base),
    .ee       (sec_ee),
    .new_psr  (nxt_psr),
    .link     (nxt_link),
    .vector   (nxt_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid  <= 1'b0;
      ent_cause  <= CAUSE_NONE;
      ent_cpsr   <= '0;
      ent_spsr   <= '0;
      ent_link   <= '0;
      ent_vector <= '0;
    end else begin
      ent_valid <= (cause != CAUSE_NONE);
      ent_cause <= cause;
      if (cause != CAUSE_NONE) begin
        ent_cpsr   <= nxt_psr;
        ent_spsr   <= work_psr;
        ent_link   <= nxt_link;
        ent_vector <= nxt_vec;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_bkpt,
  input logic        req_undef,
  input logic        req_svc,
  input logic        req_smc,
  input logic        ent_valid,
  input logic [3:0]  ent_cause,
  input logic [31:0] ent_cpsr,
  input logic [31:0] ent_spsr
);
  // R1: instruction-borne requests never overlap (input assumption)
  a_r1_insn_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_bkpt, req_undef, req_svc, req_smc}) <= 1);

  a_r10_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_valid |-> ent_cause == 4'(CAUSE_NONE));

  a_r3_tj_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (!ent_cpsr[BIT_T] && !ent_cpsr[BIT_J]));

  a_r2_fiq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_cause == 4'(CAUSE_FIQ)) |-> !ent_spsr[BIT_F]);

  a_r2_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_cause == 4'(CAUSE_IRQ)) |-> !ent_spsr[BIT_I]);

  a_r9_chain_only_fiq: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && $past(ent_valid)) |->
      (ent_cause == 4'(CAUSE_FIQ) || ent_cause == 4'(CAUSE_RESET)));

  a_r9_chain_spsr: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && $past(ent_valid) && ent_cause == 4'(CAUSE_FIQ)) |->
      ent_spsr == $past(ent_cpsr));

  a_r8_no_fiq_after_mon: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_cause == 4'(CAUSE_DABT_MON)) |=>
      !(ent_valid && ent_cause == 4'(CAUSE_FIQ)));
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_bkpt  (req_bkpt),
  .req_undef (req_undef),
  .req_svc   (req_svc),
  .req_smc   (req_smc),
  .ent_valid (ent_valid),
  .ent_cause (ent_cause),
  .ent_cpsr  (ent_cpsr),
  .ent_spsr  (ent_spsr)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [9:0]  req;   // {rst,dabt,fiq,irq,pabt,dimp,bkpt,und,svc,smc}
  logic        dext, ea, user, hv, ee;
  logic [31:0] psr;
  logic        ent_valid;
  logic [3:0]  ent_cause;
  logic [31:0] ent_cpsr, ent_spsr, ent_link, ent_vector;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n),
    .req_reset(req[9]), .req_dabt(req[8]), .req_fiq(req[7]), .req_irq(req[6]),
    .req_pabt(req[5]), .req_dabt_imp(req[4]), .req_bkpt(req[3]),
    .req_undef(req[2]), .req_svc(req[1]), .req_smc(req[0]),
    .dabt_external(dext), .ea_route(ea), .cur_psr(psr), .cur_pc(32'h0000_8000),
    .in_user(user), .hi_vectors(hv), .sec_base(32'h0000_1000),
    .ns_base(32'h0000_2000), .mon_base(32'h0000_3000), .sec_ee(ee),
    .ent_valid(ent_valid), .ent_cause(ent_cause), .ent_cpsr(ent_cpsr),
    .ent_spsr(ent_spsr), .ent_link(ent_link), .ent_vector(ent_vector)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  localparam logic [31:0] P0 = 32'h8100_003F;
  localparam logic [31:0] P1 = 32'h8100_00BF;
  localparam logic [31:0] P2 = 32'h8100_013F;
  localparam logic [31:0] P3 = 32'h8100_007F;
  localparam logic [31:0] PU = 32'h8100_0030;

  typedef struct packed {
    logic [9:0]  rq;
    logic [31:0] sp;
    logic        us, hi, dx, er;
    logic [3:0]  cause;
    logic [31:0] cpsr, vec, lnk;
  } row_t;

  localparam int NROW = 18;
  localparam row_t TBL [NROW] = '{
    '{10'h0E0, P0, 1'b0,1'b0,1'b0,1'b0, 4'd4,  32'h8000_02D1, 32'h0000_201C, 32'h0000_8004},
    '{10'h060, P0, 1'b0,1'b0,1'b0,1'b0, 4'd5,  32'h8000_0392, 32'h0000_2018, 32'h0000_8004},
    '{10'h060, P1, 1'b0,1'b0,1'b0,1'b0, 4'd6,  32'h8000_0397, 32'h0000_200C, 32'h0000_8004},
    '{10'h012, P0, 1'b0,1'b0,1'b0,1'b0, 4'd7,  32'h8000_0397, 32'h0000_2010, 32'h0000_8008},
    '{10'h012, P2, 1'b0,1'b0,1'b0,1'b0, 4'd10, 32'h8000_0393, 32'h0000_2008, 32'h0000_8004},
    '{10'h008, P0, 1'b0,1'b0,1'b0,1'b0, 4'd8,  32'h8000_0397, 32'h0000_200C, 32'h0000_8004},
    '{10'h004, P0, 1'b0,1'b1,1'b0,1'b0, 4'd9,  32'h8000_029B, 32'hFFFF_0004, 32'h0000_8004},
    '{10'h001, PU, 1'b1,1'b0,1'b0,1'b0, 4'd11, 32'h8000_029B, 32'h0000_1004, 32'h0000_8004},
    '{10'h001, PU, 1'b1,1'b1,1'b0,1'b0, 4'd11, 32'h8000_029B, 32'hFFFF_0004, 32'h0000_8004},
    '{10'h001, P0, 1'b0,1'b0,1'b0,1'b0, 4'd12, 32'h8000_03D6, 32'h0000_3008, 32'h0000_8004},
    '{10'h001, P0, 1'b0,1'b1,1'b0,1'b0, 4'd12, 32'h8000_03D6, 32'h0000_3008, 32'h0000_8004},
    '{10'h080, P0, 1'b0,1'b1,1'b0,1'b0, 4'd4,  32'h8000_02D1, 32'hFFFF_001C, 32'h0000_8004},
    '{10'h1C0, P3, 1'b0,1'b0,1'b0,1'b0, 4'd2,  32'h8000_03D7, 32'h0000_2010, 32'h0000_8008},
    '{10'h038, P0, 1'b0,1'b0,1'b0,1'b0, 4'd6,  32'h8000_0397, 32'h0000_200C, 32'h0000_8004},
    '{10'h3F8, P0, 1'b0,1'b0,1'b0,1'b0, 4'd1,  32'h8000_03D3, 32'h0000_0000, 32'h0000_0000},
    '{10'h100, P0, 1'b0,1'b0,1'b1,1'b0, 4'd2,  32'h8000_0397, 32'h0000_2010, 32'h0000_8008},
    '{10'h010, P0, 1'b0,1'b1,1'b0,1'b0, 4'd7,  32'h8000_0397, 32'hFFFF_0010, 32'h0000_8008},
    '{10'h200, P0, 1'b0,1'b1,1'b0,1'b0, 4'd1,  32'h8000_03D3, 32'hFFFF_0000, 32'h0000_0000}
  };

  task automatic idle();
    req = '0; dext = 1'b0; ea = 1'b0; user = 1'b0; hv = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    req = '0; dext = 0; ea = 0; user = 0; hv = 0; ee = 1'b1; psr = P0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset valid", 32'(ent_valid), 32'd0);
    chk("R10 reset cause", 32'(ent_cause), 32'd0);
    chk("R10 reset cpsr", ent_cpsr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle valid", 32'(ent_valid), 32'd0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NROW; i++) begin
      req = TBL[i].rq; psr = TBL[i].sp; user = TBL[i].us;
      hv = TBL[i].hi; dext = TBL[i].dx; ea = TBL[i].er;
      @(negedge clk);
      chk($sformatf("R10 row %0d valid", i), 32'(ent_valid), 32'd1);
      chk($sformatf("R1 row %0d cause", i), 32'(ent_cause), 32'(TBL[i].cause));
      chk($sformatf("R3 row %0d cpsr", i), ent_cpsr, TBL[i].cpsr);
      chk($sformatf("R4 row %0d spsr", i), ent_spsr, TBL[i].sp);
      chk($sformatf("R5 row %0d vector", i), ent_vector, TBL[i].vec);
      chk($sformatf("R4 row %0d link", i), ent_link, TBL[i].lnk);
      idle();
      chk($sformatf("R10 row %0d strobe drop", i), 32'(ent_valid), 32'd0);
    end

    // R9: data abort + fast interrupt chain
    psr = P0; req = 10'h180;
    @(negedge clk);
    chk("R9 chain first cause", 32'(ent_cause), 32'd2);
    req = 10'h080;
    @(negedge clk);
    chk("R9 chain fiq cause", 32'(ent_cause), 32'd4);
    chk("R9 chain fiq cpsr", ent_cpsr, 32'h8000_03D1);
    chk("R9 chain fiq spsr", ent_spsr, 32'h8000_0397);
    chk("R9 chain fiq link", ent_link, 32'h0000_2014);
    chk("R9 chain fiq vector", ent_vector, 32'h0000_201C);
    idle(); idle();

    // R8: routed external abort, fiq held, no chain
    req = 10'h180; dext = 1'b1; ea = 1'b1;
    @(negedge clk);
    chk("R8 monitor cause", 32'(ent_cause), 32'd3);
    chk("R8 monitor cpsr", ent_cpsr, 32'h8000_03D6);
    chk("R8 monitor vector", ent_vector, 32'h0000_3010);
    req = 10'h080;
    @(negedge clk);
    chk("R8 no chained fiq", 32'(ent_valid), 32'd0);
    idle();

    // R9: interrupt held into follow-on is ignored, taken afterwards
    req = 10'h002;
    @(negedge clk);
    chk("R9 svc first", 32'(ent_cause), 32'd10);
    req = 10'h040;
    @(negedge clk);
    chk("R9 irq ignored in follow-on", 32'(ent_valid), 32'd0);
    @(negedge clk);
    chk("R9 irq taken later", 32'(ent_cause), 32'd5);
    idle(); idle();

    // R2: reset never masked, even in follow-on
    req = 10'h002;
    @(negedge clk);
    req = 10'h200;
    @(negedge clk);
    chk("R2 reset in follow-on", 32'(ent_cause), 32'd1);
    idle(); idle();

    // R2: fully masked interrupts give no entry
    psr = 32'h0000_01DF; req = 10'h0D0;
    @(negedge clk);
    chk("R2 all masked", 32'(ent_valid), 32'd0);
    idle();

    // R3: endianness bit follows sec_ee
    ee = 1'b0; psr = P0; req = 10'h002;
    @(negedge clk);
    chk("R3 ee clear", ent_cpsr, 32'h8000_0093);
    idle(); idle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule